// File: doc/BRIEF.md
# Cartridge DMA Controller

This block is a small register-mapped engine that copies bytes between main DRAM and a cartridge address space, in either direction. Software sets a DRAM start address and a cartridge start address, then writes a length into one of two length registers. The offset of that write picks the direction, and the write itself starts the copy. The engine moves one byte at a time. For each byte it reads the source through a simple request/acknowledge memory port, then writes the destination through the other port. Source and destination addresses both ascend.

When the final byte has been written, both address registers are advanced past the copied range and realigned. The engine then stays busy for a settle time taken from an external delay input. When that time ends, busy drops and an interrupt is raised. The interrupt stays pending until software clears it through the status register. Eight 8-bit bus-timing registers, four per cartridge domain, are stored here and read back by software. The engine does not use them itself.

Top module: `cart_dma_ctrl`

## Requirements
- R1: Offset 0x00 holds the DRAM address. A write stores the value ANDed with 0x00FFFFFE, and a read returns that stored value.
- R2: Offset 0x04 holds the 32-bit cartridge address. A write stores the value with bit 0 forced to 0, and a read returns that stored value.
- R3: A write to offset 0x08 stores bits 23:0 as the read length (readable at 0x08) and starts a DRAM-to-cartridge copy of length+1 bytes. Byte i is read at DRAM address+i and written to cartridge address+i. Writes occur at strictly ascending addresses, and no byte outside the range is written.
- R4: A write to offset 0x0C stores bits 23:0 as the write length (readable at 0x0C) and starts a cartridge-to-DRAM copy of length+1 bytes. It follows the same ordering and range rules as R3.
- R5: For each byte, the source read completes before the destination write. Only one memory port requests at a time. A request whose acknowledge is low is held, with its address and write flag unchanged, until it is acknowledged.
- R6: When a copy completes, the DRAM address becomes (address + length + 1) rounded up to a multiple of 8, modulo 2^24. The cartridge address becomes address + length + 1, plus one more if that sum is odd.
- R7: A read of offset 0x10 returns bit 0 = busy, bit 1 = I/O busy (always 0), bit 2 = error (always 0), bit 3 = interrupt pending, and 0 in all other bits.
- R8: Busy rises on the clock edge that accepts a length write. It falls D+1 edges after the edge that accepts the final destination write, where D is the `doneDelay` value sampled at that edge.
- R9: The interrupt becomes pending on the same edge on which busy falls. The `irq` output equals the pending flag.
- R10: A write to offset 0x10 with bit 1 set clears the pending interrupt. A write there with bit 1 clear has no effect. If a clear and a new completion fall on the same edge, the completion wins.
- R11: Offsets 0x14, 0x18, 0x1C and 0x20 hold domain-1 latency, pulse width, page size and release. Offsets 0x24 through 0x30 hold the same four settings for domain 2. Each stores and returns only bits 7:0.
- R12: While busy is set, writes to offsets 0x00, 0x04, 0x08 and 0x0C are ignored. Neither register contents nor the transfer in progress change, and no new copy starts.
- R13: Offsets 0x34 to 0x3C, and any offset with bits 1:0 not zero, read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 6 | Register byte offset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational on regAddr |
| doneDelay | input | 16 | Settle cycles applied after the last byte |
| irq | output | 1 | Interrupt pending |
| dramReq | output | 1 | DRAM port request |
| dramWe | output | 1 | DRAM port write (1) or read (0) |
| dramAddr | output | 24 | DRAM byte address |
| dramWData | output | 8 | DRAM write byte |
| dramRData | input | 8 | DRAM read byte, valid with acknowledge |
| dramAck | input | 1 | DRAM port acknowledge |
| cartReq | output | 1 | Cartridge port request |
| cartWe | output | 1 | Cartridge port write (1) or read (0) |
| cartAddr | output | 32 | Cartridge byte address |
| cartWData | output | 8 | Cartridge write byte |
| cartRData | input | 8 | Cartridge read byte, valid with acknowledge |
| cartAck | input | 1 | Cartridge port acknowledge |

## Verification
On every cycle, the assertions check the following:
- only one memory port requests at a time;
- an unacknowledged request holds its address;
- a request never appears while busy is low;
- the interrupt only rises as busy falls, and a clear takes effect on the next edge;
- the status view agrees with the `irq` output.

Some behaviours need whole scenarios, so only the bench shows them: the copied bytes and their ascending order, the exact busy length for a given settle delay, the rounded address values after a copy, and the dropping of register writes that arrive mid-copy. The bench drives random acknowledge stalls on both ports, so the handshake timing changes from byte to byte.

// File: rtl/cdma_pkg.sv
package cdma_pkg;

  localparam int REG_DW = 32;

  // Register word indices; the length words set direction, so their order matters.
  localparam int W_DRAM  = 0;
  localparam int W_CART  = 1;
  localparam int W_RDLEN = 2;
  localparam int W_WRLEN = 3;
  localparam int W_STAT  = 4;
  localparam int W_TIM0  = 5;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SRC,
    ST_DST,
    ST_HOLD
  } cdmaState_e;

  typedef struct packed {
    logic start;
    logic capture;
    logic step;
    logic commit;
  } cdmaStrobe_t;

endpackage

// File: rtl/cdma_datapath.sv
module cdma_datapath
  import cdma_pkg::*;
#(
  parameter int LEN_W   = 24,
  parameter int DRAM_AW = 24,
  parameter int CART_AW = 32,
  parameter int TIM_W   = 8,
  parameter int TIM_N   = 8,
  parameter int RA_W    = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [RA_W-1:0]    regAddr,
  input  logic               regWrEn,
  input  logic [REG_DW-1:0]  regWrData,
  output logic [REG_DW-1:0]  regRdData,
  input  logic               busy,
  input  logic               irqPend,
  input  cdmaStrobe_t        strobe,
  input  logic               srcReq,
  input  logic               dstReq,
  output logic               hitLen,
  output logic               irqClrReq,
  output logic               lastByte,
  output logic               srcAck,
  output logic               dstAck,
  output logic               dramReq,
  output logic               dramWe,
  output logic [DRAM_AW-1:0] dramAddr,
  output logic [7:0]         dramWData,
  input  logic [7:0]         dramRData,
  input  logic               dramAck,
  output logic               cartReq,
  output logic               cartWe,
  output logic [CART_AW-1:0] cartAddr,
  output logic [7:0]         cartWData,
  input  logic [7:0]         cartRData,
  input  logic               cartAck
);

  localparam int WI_W = RA_W - 2;

  logic [WI_W-1:0]    wordIdx;
  logic               aligned;
  logic               wrAny;
  logic               wrDram, wrCart, wrRdLen;
  logic [DRAM_AW-1:0] dramPtrQ, dramSum, dramRound;
  logic [CART_AW-1:0] cartPtrQ, cartSum, cartRound;
  logic [LEN_W-1:0]   rdLenQ, wrLenQ, curLenQ, idxQ;
  logic [7:0]         dataQ, srcByte;
  logic               toCartQ;
  logic [TIM_N-1:0][REG_DW-1:0] timRdVec;

  assign wordIdx = regAddr[RA_W-1:2];
  assign aligned = (regAddr[1:0] == 2'b00);
  assign wrAny   = regWrEn && aligned;
  assign wrDram  = wrAny && (wordIdx == WI_W'(W_DRAM));
  assign wrCart  = wrAny && (wordIdx == WI_W'(W_CART));
  assign wrRdLen = wrAny && (wordIdx == WI_W'(W_RDLEN));

  assign hitLen    = wrRdLen || (wrAny && (wordIdx == WI_W'(W_WRLEN)));
  assign irqClrReq = wrAny && (wordIdx == WI_W'(W_STAT)) && regWrData[1];

  // Post-copy address realignment
  assign dramSum   = dramPtrQ + DRAM_AW'(curLenQ) + DRAM_AW'(1);
  assign dramRound = (dramSum + DRAM_AW'(7)) & ~DRAM_AW'(7);
  assign cartSum   = cartPtrQ + CART_AW'(curLenQ) + CART_AW'(1);
  assign cartRound = cartSum + CART_AW'(cartSum[0]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dramPtrQ <= '0;
      cartPtrQ <= '0;
    end else if (strobe.commit) begin
      dramPtrQ <= dramRound;
      cartPtrQ <= cartRound;
    end else if (!busy) begin
      if (wrDram) dramPtrQ <= regWrData[DRAM_AW-1:0] & ~DRAM_AW'(1);
      if (wrCart) cartPtrQ <= regWrData[CART_AW-1:0] & ~CART_AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdLenQ  <= '0;
      wrLenQ  <= '0;
      curLenQ <= '0;
      idxQ    <= '0;
      toCartQ <= 1'b0;
      dataQ   <= '0;
    end else begin
      if (strobe.start) begin
        toCartQ <= wrRdLen;
        curLenQ <= regWrData[LEN_W-1:0];
        idxQ    <= '0;
        if (wrRdLen) rdLenQ <= regWrData[LEN_W-1:0];
        else         wrLenQ <= regWrData[LEN_W-1:0];
      end
      if (strobe.capture) dataQ <= srcByte;
      if (strobe.step)    idxQ  <= idxQ + LEN_W'(1);
    end
  end

  // Per-domain timing settings, one storage slot each
  for (genvar k = 0; k < TIM_N; k++) begin : g_tim
    logic [TIM_W-1:0] valQ;
    logic             hit;
    assign hit = aligned && (wordIdx == WI_W'(W_TIM0 + k));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              valQ <= '0;
      else if (regWrEn && hit) valQ <= regWrData[TIM_W-1:0];
    end
    assign timRdVec[k] = hit ? REG_DW'(valQ) : '0;
  end

  always_comb begin
    regRdData = '0;
    if (aligned) begin
      case (wordIdx)
        WI_W'(W_DRAM):  regRdData = REG_DW'(dramPtrQ);
        WI_W'(W_CART):  regRdData = REG_DW'(cartPtrQ);
        WI_W'(W_RDLEN): regRdData = REG_DW'(rdLenQ);
        WI_W'(W_WRLEN): regRdData = REG_DW'(wrLenQ);
        WI_W'(W_STAT):  regRdData = REG_DW'({irqPend, 1'b0, 1'b0, busy});
        default: begin
          for (int k = 0; k < TIM_N; k++) regRdData = regRdData | timRdVec[k];
        end
      endcase
    end
  end

  // Port steering by direction
  assign lastByte  = (idxQ == curLenQ);
  assign srcByte   = toCartQ ? dramRData : cartRData;
  assign srcAck    = toCartQ ? dramAck : cartAck;
  assign dstAck    = toCartQ ? cartAck : dramAck;
  assign dramReq   = toCartQ ? srcReq : dstReq;
  assign cartReq   = toCartQ ? dstReq : srcReq;
  assign dramWe    = !toCartQ;
  assign cartWe    = toCartQ;
  assign dramAddr  = dramPtrQ + DRAM_AW'(idxQ);
  assign cartAddr  = cartPtrQ + CART_AW'(idxQ);
  assign dramWData = dataQ;
  assign cartWData = dataQ;

endmodule

// File: rtl/cdma_control.sv
module cdma_control
  import cdma_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hitLen,
  input  logic             irqClrReq,
  input  logic             srcAck,
  input  logic             dstAck,
  input  logic             lastByte,
  input  logic [DLY_W-1:0] doneDelay,
  output cdmaStrobe_t      strobe,
  output logic             srcReq,
  output logic             dstReq,
  output logic             busy,
  output logic             irqPend
);

  cdmaState_e       stateQ, stateD;
  logic [DLY_W-1:0] cntQ;
  logic             finishByte;
  logic             irqSet;

  assign srcReq     = (stateQ == ST_SRC);
  assign dstReq     = (stateQ == ST_DST);
  assign busy       = (stateQ != ST_IDLE);
  assign finishByte = dstReq && dstAck && lastByte;
  assign irqSet     = (stateQ == ST_HOLD) && (cntQ == '0);

  always_comb begin
    strobe = '0;
    stateD = stateQ;
    case (stateQ)
      ST_IDLE: begin
        if (hitLen) begin
          strobe.start = 1'b1;
          stateD       = ST_SRC;
        end
      end
      ST_SRC: begin
        if (srcAck) begin
          strobe.capture = 1'b1;
          stateD         = ST_DST;
        end
      end
      ST_DST: begin
        if (dstAck) begin
          if (lastByte) begin
            strobe.commit = 1'b1;
            stateD        = ST_HOLD;
          end else begin
            strobe.step = 1'b1;
            stateD      = ST_SRC;
          end
        end
      end
      ST_HOLD: begin
        if (cntQ == '0) stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      cntQ    <= '0;
      irqPend <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (finishByte)                               cntQ <= doneDelay;
      else if (stateQ == ST_HOLD && cntQ != '0)     cntQ <= cntQ - DLY_W'(1);
      if (irqSet)         irqPend <= 1'b1;
      else if (irqClrReq) irqPend <= 1'b0;
    end
  end

endmodule

// File: rtl/cart_dma_ctrl.sv
module cart_dma_ctrl
  import cdma_pkg::*;
#(
  parameter int LEN_W   = 24,
  parameter int DRAM_AW = 24,
  parameter int CART_AW = 32,
  parameter int TIM_W   = 8,
  parameter int TIM_N   = 8,
  parameter int RA_W    = 6,
  parameter int DLY_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [RA_W-1:0]    regAddr,
  input  logic               regWrEn,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  input  logic [DLY_W-1:0]   doneDelay,
  output logic               irq,
  output logic               dramReq,
  output logic               dramWe,
  output logic [DRAM_AW-1:0] dramAddr,
  output logic [7:0]         dramWData,
  input  logic [7:0]         dramRData,
  input  logic               dramAck,
  output logic               cartReq,
  output logic               cartWe,
  output logic [CART_AW-1:0] cartAddr,
  output logic [7:0]         cartWData,
  input  logic [7:0]         cartRData,
  input  logic               cartAck
);

  cdmaStrobe_t strobe;
  logic srcReq, dstReq, srcAck, dstAck;
  logic hitLen, irqClrReq, lastByte;
  logic dmaBusy, irqPend;

  assign irq = irqPend;

  cdma_datapath #(
    .LEN_W(LEN_W), .DRAM_AW(DRAM_AW), .CART_AW(CART_AW),
    .TIM_W(TIM_W), .TIM_N(TIM_N), .RA_W(RA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .busy(dmaBusy), .irqPend(irqPend), .strobe(strobe),
    .srcReq(srcReq), .dstReq(dstReq),
    .hitLen(hitLen), .irqClrReq(irqClrReq), .lastByte(lastByte),
    .srcAck(srcAck), .dstAck(dstAck),
    .dramReq(dramReq), .dramWe(dramWe), .dramAddr(dramAddr), .dramWData(dramWData),
    .dramRData(dramRData), .dramAck(dramAck),
    .cartReq(cartReq), .cartWe(cartWe), .cartAddr(cartAddr), .cartWData(cartWData),
    .cartRData(cartRData), .cartAck(cartAck)
  );

  cdma_control #(
    .DLY_W(DLY_W)
  ) u_ctl (
    .clk(clk), .rstN(rstN),
    .hitLen(hitLen), .irqClrReq(irqClrReq),
    .srcAck(srcAck), .dstAck(dstAck), .lastByte(lastByte),
    .doneDelay(doneDelay), .strobe(strobe),
    .srcReq(srcReq), .dstReq(dstReq), .busy(dmaBusy), .irqPend(irqPend)
  );

endmodule

// File: rtl/cdma_checker.sv
module cdma_checker #(
  parameter int RA_W    = 6,
  parameter int DRAM_AW = 24,
  parameter int CART_AW = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic [RA_W-1:0]    regAddr,
  input logic               regWrEn,
  input logic               clrBit,
  input logic               statBusy,
  input logic               statIrq,
  input logic               rdBit0,
  input logic               dmaBusy,
  input logic               irq,
  input logic               dramReq,
  input logic               dramWe,
  input logic [DRAM_AW-1:0] dramAddr,
  input logic               dramAck,
  input logic               cartReq,
  input logic               cartWe,
  input logic [CART_AW-1:0] cartAddr,
  input logic               cartAck
);

  AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rstN)
    !(dramReq && cartReq)); // R5

  AST_DRAM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    dramReq && !dramAck |=> dramReq && $stable(dramAddr) && $stable(dramWe)); // R5

  AST_CART_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    cartReq && !cartAck |=> cartReq && $stable(cartAddr) && $stable(cartWe)); // R5

  AST_REQ_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (dramReq || cartReq) |-> dmaBusy); // R8

  AST_IRQ_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $fell(dmaBusy)); // R9

  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regAddr == RA_W'(16) && clrBit |=> !irq || $fell(dmaBusy)); // R10

  AST_STATUS_VIEW: assert property (@(posedge clk) disable iff (!rstN)
    regAddr == RA_W'(16) |-> statIrq == irq && statBusy == dmaBusy); // R7

  AST_DRAM_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    regAddr == RA_W'(0) |-> !rdBit0); // R1

endmodule

bind cart_dma_ctrl cdma_checker #(
  .RA_W(RA_W), .DRAM_AW(DRAM_AW), .CART_AW(CART_AW)
) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
  .clrBit(regWrData[1]), .statBusy(regRdData[0]), .statIrq(regRdData[3]),
  .rdBit0(regRdData[0]), .dmaBusy(dmaBusy), .irq(irq),
  .dramReq(dramReq), .dramWe(dramWe), .dramAddr(dramAddr), .dramAck(dramAck),
  .cartReq(cartReq), .cartWe(cartWe), .cartAddr(cartAddr), .cartAck(cartAck)
);

// File: tb/tb_cart_dma_ctrl.sv
module tb_cart_dma_ctrl;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  regAddr = 6'h10;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [15:0] doneDelay = '0;
  logic        irq;
  logic        dramReq, dramWe, dramAck = 1'b0;
  logic [23:0] dramAddr;
  logic [7:0]  dramWData, dramRData;
  logic        cartReq, cartWe, cartAck = 1'b0;
  logic [31:0] cartAddr;
  logic [7:0]  cartWData, cartRData;

  logic [7:0] dramMem [1024];
  logic [7:0] cartMem [1024];

  int nChk = 0, nFail = 0, cyc = 0, lastWrCyc = 0, wrCount = 0, orderErr = 0;
  logic [31:0] prevWr = '0;
  logic [31:0] lastWrLen = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cart_dma_ctrl dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .doneDelay(doneDelay), .irq(irq),
    .dramReq(dramReq), .dramWe(dramWe), .dramAddr(dramAddr), .dramWData(dramWData),
    .dramRData(dramRData), .dramAck(dramAck),
    .cartReq(cartReq), .cartWe(cartWe), .cartAddr(cartAddr), .cartWData(cartWData),
    .cartRData(cartRData), .cartAck(cartAck)
  );

  assign dramRData = dramMem[dramAddr[9:0]];
  assign cartRData = cartMem[cartAddr[9:0]];

  // Memory models: random stalls, writes logged for order and timing
  always @(negedge clk) begin
    dramAck = ($urandom % 4) != 0;
    cartAck = ($urandom % 3) != 0;
  end

  always @(posedge clk) begin
    if (dramReq && dramAck && dramWe) begin
      if (wrCount > 0 && {8'h0, dramAddr} != prevWr + 1) orderErr++;
      prevWr = {8'h0, dramAddr};
      dramMem[dramAddr[9:0]] = dramWData;
      wrCount++;
      lastWrCyc = cyc;
    end
    if (cartReq && cartAck && cartWe) begin
      if (wrCount > 0 && cartAddr != prevWr + 1) orderErr++;
      prevWr = cartAddr;
      cartMem[cartAddr[9:0]] = cartWData;
      wrCount++;
      lastWrCyc = cyc;
    end
    cyc++;
  end

  function automatic logic [31:0] expDramNext(input logic [31:0] a, input logic [31:0] n);
    logic [31:0] s;
    s = (a + n) & 32'h00FF_FFFF;
    s = (s + 32'd7) & 32'h00FF_FFF8;
    return s;
  endfunction

  function automatic logic [31:0] expCartNext(input logic [31:0] c, input logic [31:0] n);
    logic [31:0] s;
    s = c + n;
    if (s[0]) s = s + 32'd1;
    return s;
  endfunction

  task automatic chkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 6'h10;
  endtask

  task automatic regRead(input logic [5:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdData;
    regAddr = 6'h10;
  endtask

  task automatic doXfer(input bit toCart, input logic [31:0] dA, input logic [31:0] cA,
                        input logic [31:0] len, input logic [15:0] dly, input bit poke);
    logic [31:0] n, dB, cB, rd, sentinel;
    int mism, fallCyc;
    string tag;
    tag = toCart ? "R3" : "R4";
    n  = len + 1;
    dB = dA & 32'h00FF_FFFE;
    cB = cA & 32'hFFFF_FFFE;
    for (int i = 0; i < 1024; i++) begin
      dramMem[i] = 8'($urandom);
      cartMem[i] = 8'($urandom);
    end
    sentinel = toCart ? {24'h0, cartMem[(cB + n) & 1023]} : {24'h0, dramMem[(dB + n) & 1023]};
    regWrite(6'h00, dA);
    regWrite(6'h04, cA);
    doneDelay = dly;
    wrCount = 0; orderErr = 0;
    regWrite(toCart ? 6'h08 : 6'h0C, len);
    regRead(6'h10, rd);
    chkEq("R8 busy after start", {31'h0, rd[0]}, 32'h1);
    if (poke) begin
      regWrite(6'h08, 32'h0000_ABCD);
      regWrite(6'h00, 32'h0000_0200);
      regWrite(6'h04, 32'h0000_0300);
      regWrite(6'h0C, 32'h0000_0005);
    end
    fallCyc = 0;
    forever begin
      @(negedge clk);
      if (!regRdData[0]) begin
        fallCyc = cyc;
        break;
      end
    end
    chkEq("R8 busy span after last write", fallCyc - lastWrCyc, 32'(dly) + 2);
    chkEq("R9 irq at busy fall", {31'h0, irq}, 32'h1);
    chkEq({tag, " byte count"}, wrCount, n);
    chkEq({tag, " ascending order"}, orderErr, 0);
    mism = 0;
    for (int i = 0; i < int'(n); i++) begin
      if (toCart) begin
        if (cartMem[(cB + i) & 1023] !== dramMem[(dB + i) & 1023]) mism++;
      end else begin
        if (dramMem[(dB + i) & 1023] !== cartMem[(cB + i) & 1023]) mism++;
      end
    end
    chkEq({tag, " data copied"}, mism, 0);
    chkEq({tag, " byte past range untouched"},
          toCart ? {24'h0, cartMem[(cB + n) & 1023]} : {24'h0, dramMem[(dB + n) & 1023]}, sentinel);
    regRead(6'h00, rd);
    chkEq(poke ? "R6 R12 dram address update" : "R6 dram address update", rd, expDramNext(dB, n));
    regRead(6'h04, rd);
    chkEq(poke ? "R6 R12 cart address update" : "R6 cart address update", rd, expCartNext(cB, n));
    regRead(toCart ? 6'h08 : 6'h0C, rd);
    chkEq(poke ? "R12 length kept" : {tag, " length readback"}, rd, len & 32'h00FF_FFFF);
    if (!toCart) lastWrLen = len & 32'h00FF_FFFF;
    if (poke) begin
      regRead(6'h0C, rd);
      chkEq("R12 other length kept", rd, lastWrLen);
    end
    regRead(6'h10, rd);
    chkEq("R7 status after done", rd, 32'h8);
    regWrite(6'h10, 32'hFFFF_FFFD);
    chkEq("R10 clear with bit1 low ignored", {31'h0, irq}, 32'h1);
    regWrite(6'h10, 32'h0000_0002);
    chkEq("R10 clear", {31'h0, irq}, 32'h0);
    regRead(6'h10, rd);
    chkEq("R7 status idle", rd, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL R8 watchdog: actual hang expected completion");
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, v;
    void'($urandom(32'd2024));
    for (int i = 0; i < 1024; i++) begin
      dramMem[i] = '0;
      cartMem[i] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // Reset state
    regRead(6'h10, rd); chkEq("R7 reset status", rd, 32'h0);
    regRead(6'h00, rd); chkEq("R1 reset dram address", rd, 32'h0);
    regRead(6'h08, rd); chkEq("R3 reset length", rd, 32'h0);
    chkEq("R9 reset irq", {31'h0, irq}, 32'h0);

    // Address masking
    regWrite(6'h00, 32'hFFFF_FFFF); regRead(6'h00, rd); chkEq("R1 dram mask", rd, 32'h00FF_FFFE);
    regWrite(6'h00, 32'h1234_5679); regRead(6'h00, rd); chkEq("R1 dram mask", rd, 32'h0034_5678);
    regWrite(6'h04, 32'hFFFF_FFFF); regRead(6'h04, rd); chkEq("R2 cart mask", rd, 32'hFFFF_FFFE);

    // Timing settings
    for (int k = 0; k < 8; k++) begin
      v = $urandom;
      regWrite(6'(6'h14 + 4 * k), v);
      regRead(6'(6'h14 + 4 * k), rd);
      chkEq("R11 timing setting", rd, v & 32'hFF);
    end

    // Unmapped and misaligned offsets
    regWrite(6'h34, 32'hFFFF_FFFF); regRead(6'h34, rd); chkEq("R13 unmapped read", rd, 32'h0);
    regRead(6'h3C, rd); chkEq("R13 unmapped read", rd, 32'h0);
    regWrite(6'h15, 32'h0000_0077); regRead(6'h15, rd); chkEq("R13 misaligned read", rd, 32'h0);
    regWrite(6'h14, 32'h0000_0011);
    regWrite(6'h15, 32'h0000_0077); regRead(6'h14, rd); chkEq("R13 misaligned write ignored", rd, 32'h11);

    // Directed corners
    doXfer(1'b1, 32'h0000_0010, 32'h1000_0021, 32'h0, 16'd0, 1'b0);
    doXfer(1'b0, 32'h0000_0033, 32'h0800_0100, 32'd15, 16'd3, 1'b0);
    doXfer(1'b0, 32'hFF00_0005, 32'h0000_0040, 32'd6, 16'd1, 1'b0);
    doXfer(1'b1, 32'h0000_0040, 32'h0000_0100, 32'd20, 16'd60, 1'b1);

    // Constrained random transfers
    for (int t = 0; t < 10; t++) begin
      doXfer(1'($urandom), 32'($urandom % 512), ($urandom & 32'hFFFF_0000) | 32'($urandom % 512),
             32'($urandom % 64), 16'($urandom % 24), 1'b0);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

endmodule